// File: doc/BRIEF.md
# Cascadable Bit-Slice Arithmetic Logic Unit

This block is an arithmetic logic unit of configurable width, made from identical one-bit slices. Each slice takes one bit of each operand and the carry from the slice below it. It produces one result bit and a carry for the slice above. The slices are joined by a ripple carry chain.

A 3-bit operation code selects one of eight functions: four arithmetic and four bitwise. Inside each slice, an arithmetic cell and a logic cell work side by side. The top bit of the operation code picks which of the two drives the result bit. A small generator turns the operation code into the carry fed to the lowest slice.

The result and the carry out of the top slice are captured in output registers. A new answer appears one clock after its operands are applied.

Top module: `sliced_alu`

## Requirements
- R1: Operation code 3'b000 registers (A + B) mod 2^W as the result, and the carry out of bit W-1 as the carry flag.
- R2: Operation code 3'b001 registers (A - B) mod 2^W. The carry flag is 1 exactly when A >= B (unsigned), meaning no borrow occurred.
- R3: Operation code 3'b010 registers (A + 1) mod 2^W. The carry flag is 1 only when A is all ones. B has no effect on either output.
- R4: Operation code 3'b011 registers (A - 1) mod 2^W. The carry flag is 1 exactly when A is nonzero. B has no effect on either output.
- R5: Operation code 3'b100 registers A AND B, and operation code 3'b101 registers A OR B, bit by bit.
- R6: Operation code 3'b110 registers NOT A, with B having no effect. Operation code 3'b111 registers A XOR B.
- R7: For every operation code whose top bit is 1, the registered carry flag is 0.
- R8: Operands and operation code sampled at one rising clock edge determine the outputs seen after that edge. Those outputs hold until the next edge.
- R9: When the active-high reset is high at a rising edge, the result and the carry flag become 0 after that edge.
- R10: The width parameter W changes only the number of slices. The same eight functions hold at any width, including the wraparound when incrementing all ones or decrementing zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code |
| opnd_a | input | W | Operand A |
| opnd_b | input | W | Operand B |
| res_q | output | W | Registered result |
| cout_q | output | 1 | Registered carry out of the top slice |

## Verification
The bench builds two copies of the block side by side, one with W = 4 and one with W = 9. At width 4, all eight operations run over every operand pair, which covers each carry and borrow boundary completely. The width-9 copy runs on random operands plus directed wraparound cases. It shows that the slice cascade and the carry generator behave the same once the chain is longer than the exhaustive case.

// File: rtl/sliced_alu_pkg.sv
package sliced_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_INC  = 3'b010,
        OP_DEC  = 3'b011,
        OP_AND  = 3'b100,
        OP_OR   = 3'b101,
        OP_NOTA = 3'b110,
        OP_XOR  = 3'b111
    } alu_op_e;

    typedef struct packed {
        logic f;
        logic co;
    } slice_out_t;

    // Operand-B conditioning for the arithmetic cell, chosen by op[1:0].
    function automatic logic cond_b(input logic [1:0] mode, input logic b);
        case (mode)
            2'b00:   return b;
            2'b01:   return ~b;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    // Carry injected into the lowest slice.
    function automatic logic first_carry(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_INC);
    endfunction

endpackage

// File: rtl/alu_arith_cell.sv
module alu_arith_cell
    import sliced_alu_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       a,
    input  logic       b,
    input  logic       ci,
    output slice_out_t out
);
    logic bx;

    always_comb begin
        bx     = cond_b(mode, b);
        out.f  = a ^ bx ^ ci;
        out.co = (a & bx) | (a & ci) | (bx & ci);
    end
endmodule

// File: rtl/alu_logic_cell.sv
module alu_logic_cell (
    input  logic [1:0] mode,
    input  logic       a,
    input  logic       b,
    output logic       f
);
    always_comb begin
        case (mode)
            2'b00:   f = a & b;
            2'b01:   f = a | b;
            2'b10:   f = ~a;
            default: f = a ^ b;
        endcase
    end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import sliced_alu_pkg::*;
(
    input  logic [2:0] op,
    input  logic       a,
    input  logic       b,
    input  logic       ci,
    output slice_out_t out
);
    slice_out_t arith;
    logic       lgc;

    alu_arith_cell u_arith (
        .mode (op[1:0]),
        .a    (a),
        .b    (b),
        .ci   (ci),
        .out  (arith)
    );

    alu_logic_cell u_logic (
        .mode (op[1:0]),
        .a    (a),
        .b    (b),
        .f    (lgc)
    );

    always_comb begin
        out.f  = op[2] ? lgc : arith.f;
        out.co = arith.co;
    end
endmodule

// File: rtl/alu_carry_gen.sv
module alu_carry_gen
    import sliced_alu_pkg::*;
(
    input  logic [2:0] op,
    output logic       c0
);
    assign c0 = first_carry(alu_op_e'(op));
endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
    import sliced_alu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] res_q,
    output logic         cout_q
);
    localparam int CHAIN = W + 1;

    logic [CHAIN-1:0] carry;
    logic [W-1:0]     f_bits;
    logic             is_logic;

    alu_carry_gen u_cgen (
        .op (op_sel),
        .c0 (carry[0])
    );

    for (genvar i = 0; i < W; i++) begin : g_slice
        slice_out_t so;
        alu_bit_slice u_slice (
            .op  (op_sel),
            .a   (opnd_a[i]),
            .b   (opnd_b[i]),
            .ci  (carry[i]),
            .out (so)
        );
        assign f_bits[i]  = so.f;
        assign carry[i+1] = so.co;
    end

    assign is_logic = (alu_op_e'(op_sel) inside {OP_AND, OP_OR, OP_NOTA, OP_XOR});

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            cout_q <= 1'b0;
        end else begin
            res_q  <= f_bits;
            cout_q <= is_logic ? 1'b0 : carry[W];
        end
    end
endmodule

// File: rtl/sliced_alu_chk.sv
module sliced_alu_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   op_sel,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] res_q,
    input logic         cout_q
);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (res_q == '0 && cout_q == 1'b0));

    // R7
    logic_carry_zero_chk: assert property (@(posedge clk) disable iff (rst)
        op_sel[2] |=> (cout_q == 1'b0));

    // R1
    add_result_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b000) |=>
        ({cout_q, res_q} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)})));

    // R2
    sub_borrow_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b001) |=>
        (res_q == W'($past(opnd_a) - $past(opnd_b)) &&
         cout_q == ($past(opnd_a) >= $past(opnd_b))));

    // R5
    and_result_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b100) |=> (res_q == ($past(opnd_a) & $past(opnd_b))));

    // R6
    xor_result_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b111) |=> (res_q == ($past(opnd_a) ^ $past(opnd_b))));

    // R3
    inc_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 3'b010) |=> (cout_q == (&$past(opnd_a))));
endmodule

bind sliced_alu sliced_alu_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .res_q  (res_q),
    .cout_q (cout_q)
);

// File: tb/sliced_alu_test.sv
`timescale 1ns/1ps
module sliced_alu_test;
    localparam int WN = 4;
    localparam int WW = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    op  = 3'b000;
    logic [WN-1:0] a4 = '0, b4 = '0;
    logic [WW-1:0] a9 = '0, b9 = '0;
    logic [WN-1:0] r4;
    logic [WW-1:0] r9;
    logic          c4, c9;
    int            checks = 0;
    int            errors = 0;

    always #5 clk = ~clk;

    sliced_alu #(.W(WN)) uut (
        .clk(clk), .rst(rst), .op_sel(op), .opnd_a(a4), .opnd_b(b4),
        .res_q(r4), .cout_q(c4)
    );

    sliced_alu #(.W(WW)) u_wide (
        .clk(clk), .rst(rst), .op_sel(op), .opnd_a(a9), .opnd_b(b9),
        .res_q(r9), .cout_q(c9)
    );

    // Reference model: {carry, result} in bits [16] and [15:0].
    function automatic logic [16:0] model(input logic [2:0] o, input logic [15:0] a,
                                          input logic [15:0] b, input int w);
        logic [31:0] mask, full;
        logic [15:0] res;
        logic        cy;
        mask = (32'd1 << w) - 32'd1;
        full = '0;
        cy   = 1'b0;
        case (o)
            3'b000: full = {16'd0, a} + {16'd0, b};
            3'b001: full = {16'd0, a} + (~{16'd0, b} & mask) + 32'd1;
            3'b010: full = {16'd0, a} + 32'd1;
            3'b011: full = {16'd0, a} + mask;
            3'b100: full = {16'd0, a & b};
            3'b101: full = {16'd0, a | b};
            3'b110: full = ~{16'd0, a};
            default: full = {16'd0, a ^ b};
        endcase
        res = 16'(full & mask);
        if (!o[2]) cy = full[w];
        return {cy, res};
    endfunction

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'b000: return "R1";
            3'b001: return "R2";
            3'b010: return "R3";
            3'b011: return "R4";
            3'b100, 3'b101: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%b actual=%h expected=%h", req, op, act, exp);
        end
    endtask

    // Drive at the falling edge, sample 1 ns after the next rising edge (R8).
    task automatic apply(input logic [2:0] o, input logic [WN-1:0] x4, input logic [WN-1:0] y4,
                         input logic [WW-1:0] x9, input logic [WW-1:0] y9);
        logic [16:0] e4, e9;
        @(negedge clk);
        op = o; a4 = x4; b4 = y4; a9 = x9; b9 = y9;
        e4 = model(o, 16'(x4), 16'(y4), WN);
        e9 = model(o, 16'(x9), 16'(y9), WW);
        @(posedge clk);
        #1;
        check(req_of(o), {c4, 12'd0, r4}, e4);
        check({req_of(o), "/R10"}, {c9, 7'd0, r9}, e9);
        if (o[2]) check("R7", {16'd0, c4 | c9}, 17'd0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (2) @(posedge clk);
        #1;
        // R9: reset state
        check("R9", {c4, 12'd0, r4}, 17'd0);
        check("R9", {c9, 7'd0, r9}, 17'd0);
        @(negedge clk);
        rst = 1'b0;

        // Exhaustive at width 4, random operands on the wide copy.
        for (int o = 0; o < 8; o++)
            for (int x = 0; x < 16; x++)
                for (int y = 0; y < 16; y++)
                    apply(3'(o), 4'(x), 4'(y), 9'($urandom), 9'($urandom));

        // R3/R4/R10 wraparound corners; B varied to show it is ignored.
        apply(3'b010, 4'hF, 4'h0, 9'h1FF, 9'h000);
        apply(3'b010, 4'hF, 4'hA, 9'h1FF, 9'h155);
        apply(3'b011, 4'h0, 4'h0, 9'h000, 9'h000);
        apply(3'b011, 4'h0, 4'hF, 9'h000, 9'h1FF);
        apply(3'b001, 4'h0, 4'h1, 9'h000, 9'h001);
        apply(3'b000, 4'hF, 4'hF, 9'h1FF, 9'h1FF);
        apply(3'b110, 4'h5, 4'hF, 9'h0AA, 9'h1FF);

        // R8: outputs hold with no edge while inputs change.
        @(negedge clk);
        op = 3'b000; a4 = 4'h3; b4 = 4'h4; a9 = 9'd7; b9 = 9'd8;
        @(posedge clk);
        #1;
        op = 3'b111; a4 = 4'hC; b4 = 4'h3; a9 = 9'h0F0; b9 = 9'h00F;
        #3;
        check("R8", {c4, 12'd0, r4}, 17'd7);
        check("R8", {c9, 7'd0, r9}, 17'd15);

        // Random mix on both widths.
        for (int k = 0; k < 400; k++)
            apply(3'($urandom), 4'($urandom), 4'($urandom), 9'($urandom), 9'($urandom));

        // R9: reset mid-run clears the outputs.
        apply(3'b000, 4'hE, 4'h3, 9'h1F0, 9'h020);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R9", {c4, 12'd0, r4}, 17'd0);
        check("R9", {c9, 7'd0, r9}, 17'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule